// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Bank

This block is a bank of general-purpose I/O lines behind a small synchronous register bus. Each line has three pad signals: a driven value, an output enable and a sampled input. Software controls the lines by writing registers and reads back either what it drives or what the pins show. Two parameters, fixed at elaboration, set how the registers behave.

The first parameter picks how outputs are written. The choices are a single read/write data register, a pair of write-one-to-set and write-one-to-clear registers, or a plain output register combined with a read-only register that returns the pin levels. The second parameter picks how direction is set. Lines can all be fixed as bidirectional with their drivers always on. They can instead be controlled by a direction register in which a 1 means output, or by one in which a 1 means input.

Pin inputs pass through a two-stage synchroniser before software can see them. Writes change the pads on the clock edge that samples the write. Reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, pad_out is all zeros and every line is an input. With the 1-means-output direction style, pad_oe is 0 and the direction register (byte offset 0xC) reads 0. With the 1-means-input style, pad_oe is 0 and the direction register reads all ones. With the fixed style, pad_oe is all ones.
- R2: In single-register style, a write to offset 0x0 replaces the output latch with the written word. pad_out shows the new value after the clock edge that samples the write. The latch holds its value in every cycle with no write that targets it.
- R3: In set/clear style, writing a 1 to a bit at offset 0x4 makes that output bit 1, and writing a 1 to a bit at offset 0x8 makes it 0. Bits written as 0 keep their value.
- R4: In set/clear style, reads of offset 0x4 and of offset 0x8 both return the output latch. In set-plus-data style, a read of offset 0x4 returns the output latch.
- R5: In set-plus-data style, a write to offset 0x4 replaces the output latch. A read of offset 0x0 returns the synchronised level of every line, whatever its direction. Writes to offset 0x0 change nothing.
- R6: With the 1-means-output style, a write to offset 0xC loads the direction register, and pad_oe equals that register.
- R7: With the 1-means-input style, a write to offset 0xC loads the direction register, and pad_oe is its bitwise inverse.
- R8: With the fixed style, pad_oe is all ones and offset 0xC reads 0 and ignores writes.
- R9: A change on pad_in first shows in read data after the second rising edge that follows it, and not after the first.
- R10: In single-register and set/clear styles, a read of offset 0x0 returns the output latch on lines whose output enable is 1 and the synchronised input on the other lines.
- R11: Registers not used by the chosen styles, and every address other than 0x0, 0x4, 0x8 and 0xC, read as zero and ignore writes.
- R12: bus_rdata reflects a new bus_addr within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Combinational read data |
| pad_out | output | N_LINES | Value driven on each line |
| pad_oe | output | N_LINES | Output enable per line |
| pad_in | input | N_LINES | Raw level seen on each line |

## Verification
The bench runs three copies of the bank, one in each data style and each with a different direction style, all driven from the same bus. A write meant for one style therefore lands on the ignored registers of the other two. A design that decoded an unused register would corrupt a latch there, and a design that let a zero bit of a set or clear write disturb the latch would drift away from the model. Directed steps cover the reset values of the two direction polarities and the two-edge input delay. A synchroniser with one stage too few or too many gives a read value that is early or late. The random mix of input and output lines checks the per-line merge in the data read, which an inverted enable polarity would get backwards.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    DS_SINGLE  = 2'd0,
    DS_SETCLR  = 2'd1,
    DS_SETDATA = 2'd2
  } data_style_e;

  typedef enum logic [1:0] {
    DIR_FIXED  = 2'd0,
    DIR_OUT_HI = 2'd1,
    DIR_IN_HI  = 2'd2
  } dir_style_e;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_SET  = 4;
  localparam int unsigned OFS_CLR  = 8;
  localparam int unsigned OFS_DIR  = 12;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= raw_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch import gpio_bank_pkg::*; #(
  parameter int          W          = 8,
  parameter data_style_e DATA_STYLE = DS_SINGLE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_data,
  input  logic         hit_set,
  input  logic         hit_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q
);

  // Next latch value; when set and clear both hit, clear wins.
  function automatic logic [W-1:0] next_latch(
    input logic [W-1:0] cur,
    input logic [W-1:0] wd,
    input logic         h_data,
    input logic         h_set,
    input logic         h_clr
  );
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;
    set_m = h_set ? wd : '0;
    clr_m = h_clr ? wd : '0;
    case (DATA_STYLE)
      DS_SINGLE:  next_latch = h_data ? wd : cur;
      DS_SETCLR:  next_latch = (cur | set_m) & ~clr_m;
      DS_SETDATA: next_latch = h_set ? wd : cur;
      default:    next_latch = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= next_latch(latch_q, wdata, hit_data, hit_set, hit_clr);
  end

endmodule

// File: rtl/gpio_dir_ctl.sv
module gpio_dir_ctl import gpio_bank_pkg::*; #(
  parameter int         W         = 8,
  parameter dir_style_e DIR_STYLE = DIR_OUT_HI
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] oe
);

  // Reset value that makes every line an input.
  localparam logic [W-1:0] DIR_RESET = (DIR_STYLE == DIR_IN_HI) ? {W{1'b1}} : {W{1'b0}};

  function automatic logic [W-1:0] oe_of(input logic [W-1:0] d);
    case (DIR_STYLE)
      DIR_OUT_HI: oe_of = d;
      DIR_IN_HI:  oe_of = ~d;
      default:    oe_of = '1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= DIR_RESET;
    else if (hit_dir) dir_q <= wdata;
  end

  assign oe = oe_of(dir_q);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_bank_pkg::*; #(
  parameter int          N_LINES    = 8,
  parameter int          ADDR_W     = 4,
  parameter data_style_e DATA_STYLE = DS_SINGLE,
  parameter dir_style_e  DIR_STYLE  = DIR_OUT_HI,
  parameter int          SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  output logic [N_LINES-1:0] pad_out,
  output logic [N_LINES-1:0] pad_oe,
  input  logic [N_LINES-1:0] pad_in
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

  localparam bit DATA_WR_EN = (DATA_STYLE == DS_SINGLE);
  localparam bit SET_EN     = (DATA_STYLE != DS_SINGLE);
  localparam bit CLR_EN     = (DATA_STYLE == DS_SETCLR);
  localparam bit DIR_EN     = (DIR_STYLE != DIR_FIXED);

  // Decode events, named for the checker.
  logic sel_data, sel_set, sel_clr, sel_dir, addr_mapped;
  logic wr_data_hit, wr_set_hit, wr_clr_hit, wr_dir_hit;
  logic [N_LINES-1:0] latch_q, dir_q, in_sync;

  assign sel_data    = (bus_addr == A_DATA);
  assign sel_set     = (bus_addr == A_SET);
  assign sel_clr     = (bus_addr == A_CLR);
  assign sel_dir     = (bus_addr == A_DIR);
  assign addr_mapped = sel_data | sel_set | sel_clr | sel_dir;

  assign wr_data_hit = bus_we & sel_data & DATA_WR_EN;
  assign wr_set_hit  = bus_we & sel_set  & SET_EN;
  assign wr_clr_hit  = bus_we & sel_clr  & CLR_EN;
  assign wr_dir_hit  = bus_we & sel_dir  & DIR_EN;

  gpio_out_latch #(.W(N_LINES), .DATA_STYLE(DATA_STYLE)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_data (wr_data_hit),
    .hit_set  (wr_set_hit),
    .hit_clr  (wr_clr_hit),
    .wdata    (bus_wdata),
    .latch_q  (latch_q)
  );

  gpio_dir_ctl #(.W(N_LINES), .DIR_STYLE(DIR_STYLE)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_dir (wr_dir_hit),
    .wdata   (bus_wdata),
    .dir_q   (dir_q),
    .oe      (pad_oe)
  );

  gpio_in_sync #(.W(N_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (in_sync)
  );

  // Data-register view: output lines show the latch, input lines the pins.
  function automatic logic [N_LINES-1:0] data_view(
    input logic [N_LINES-1:0] lat,
    input logic [N_LINES-1:0] sy,
    input logic [N_LINES-1:0] en
  );
    if (DATA_STYLE == DS_SETDATA) data_view = sy;
    else                          data_view = (lat & en) | (sy & ~en);
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (sel_data)              bus_rdata = data_view(latch_q, in_sync, pad_oe);
    else if (sel_set && SET_EN) bus_rdata = latch_q;
    else if (sel_clr && CLR_EN) bus_rdata = latch_q;
    else if (sel_dir && DIR_EN) bus_rdata = dir_q;
  end

  assign pad_out = latch_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk import gpio_bank_pkg::*; #(
  parameter int          W          = 8,
  parameter data_style_e DATA_STYLE = DS_SINGLE,
  parameter int          SYNC_DEPTH = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_in,
  input logic         addr_mapped,
  input logic         wr_data_hit,
  input logic         wr_set_hit,
  input logic         wr_clr_hit,
  input logic         wr_dir_hit,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] in_sync
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (pad_out == '0 && latch_q == '0); // R1
    end
  end

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (DATA_STYLE == DS_SETCLR && wr_set_hit && !wr_clr_hit)
      |=> ((latch_q & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (DATA_STYLE == DS_SETCLR && wr_clr_hit)
      |=> ((latch_q & $past(bus_wdata)) == '0)); // R3

  AST_WHOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (DATA_STYLE != DS_SETCLR && (wr_data_hit || wr_set_hit))
      |=> (pad_out == $past(bus_wdata))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data_hit || wr_set_hit || wr_clr_hit) |=> $stable(latch_q)); // R2

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_hit |=> (dir_q == $past(bus_wdata))); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (bus_rdata == '0)); // R11

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (SYNC_DEPTH == 2 && age_q >= 2'd2) |-> (in_sync == $past(pad_in, 2))); // R9

endmodule

bind gpio_bank gpio_bank_chk #(
  .W          (N_LINES),
  .DATA_STYLE (DATA_STYLE),
  .SYNC_DEPTH (SYNC_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pad_out     (pad_out),
  .pad_in      (pad_in),
  .addr_mapped (addr_mapped),
  .wr_data_hit (wr_data_hit),
  .wr_set_hit  (wr_set_hit),
  .wr_clr_hit  (wr_clr_hit),
  .wr_dir_hit  (wr_dir_hit),
  .latch_q     (latch_q),
  .dir_q       (dir_q),
  .in_sync     (in_sync)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  import gpio_bank_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = 4'hC;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] pin = '0;

  logic [7:0] rd_a, out_a, oe_a;
  logic [7:0] rd_b, out_b, oe_b;
  logic [7:0] rd_c, out_c, oe_c;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // A: single register, 1-means-output direction
  gpio_bank #(.N_LINES(8), .ADDR_W(4), .DATA_STYLE(DS_SINGLE), .DIR_STYLE(DIR_OUT_HI)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd_a), .pad_out(out_a), .pad_oe(oe_a), .pad_in(pin));
  // B: set/clear, 1-means-input direction
  gpio_bank #(.N_LINES(8), .ADDR_W(4), .DATA_STYLE(DS_SETCLR), .DIR_STYLE(DIR_IN_HI)) i_gpio_bank_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd_b), .pad_out(out_b), .pad_oe(oe_b), .pad_in(pin));
  // C: set plus data, fixed direction
  gpio_bank #(.N_LINES(8), .ADDR_W(4), .DATA_STYLE(DS_SETDATA), .DIR_STYLE(DIR_FIXED)) i_gpio_bank_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd_c), .pad_out(out_c), .pad_oe(oe_c), .pad_in(pin));

  // Bench model, written from the requirements.
  logic [7:0] m_la, m_lb, m_lc, m_da, m_db, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_la <= '0; m_lb <= '0; m_lc <= '0;
      m_da <= '0; m_db <= '1;
      m_s1 <= '0; m_s2 <= '0;
    end else begin
      m_s1 <= pin;
      m_s2 <= m_s1;
      if (we) begin
        case (addr)
          4'h0: m_la <= wd;
          4'h4: begin m_lb <= m_lb | wd; m_lc <= wd; end
          4'h8: m_lb <= m_lb & ~wd;
          4'hC: begin m_da <= wd; m_db <= wd; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] merge(input logic [7:0] lat, input logic [7:0] en, input logic [7:0] sy);
    return (lat & en) | (sy & ~en);
  endfunction

  function automatic logic [7:0] exp_rd_a(input logic [3:0] a);
    case (a)
      4'h0:    return merge(m_la, m_da, m_s2);
      4'hC:    return m_da;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd_b(input logic [3:0] a);
    case (a)
      4'h0:         return merge(m_lb, ~m_db, m_s2);
      4'h4, 4'h8:   return m_lb;
      4'hC:         return m_db;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd_c(input logic [3:0] a);
    case (a)
      4'h0:    return m_s2;
      4'h4:    return m_lc;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_a(input logic [3:0] a);
    case (a) 4'h0: return "R10"; 4'hC: return "R6"; default: return "R11"; endcase
  endfunction
  function automatic string tag_b(input logic [3:0] a);
    case (a) 4'h0: return "R10"; 4'h4, 4'h8: return "R4"; 4'hC: return "R7"; default: return "R11"; endcase
  endfunction
  function automatic string tag_c(input logic [3:0] a);
    case (a) 4'h0: return "R5"; 4'h4: return "R4"; 4'hC: return "R8"; default: return "R11"; endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "A pad_out", out_a, m_la);
    chk("R3", "B pad_out", out_b, m_lb);
    chk("R5", "C pad_out", out_c, m_lc);
    chk("R6", "A pad_oe", oe_a, m_da);
    chk("R7", "B pad_oe", oe_b, ~m_db);
    chk("R8", "C pad_oe", oe_c, 8'hFF);
    chk(tag_a(addr), "A rdata", rd_a, exp_rd_a(addr));
    chk(tag_b(addr), "B rdata", rd_b, exp_rd_b(addr));
    chk(tag_c(addr), "C rdata", rd_c, exp_rd_c(addr));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset values, direction register selected
    repeat (3) @(negedge clk);
    chk("R1", "A pad_out", out_a, 8'h00);
    chk("R1", "B pad_out", out_b, 8'h00);
    chk("R1", "A pad_oe", oe_a, 8'h00);
    chk("R1", "B pad_oe", oe_b, 8'h00);
    chk("R1", "C pad_oe", oe_c, 8'hFF);
    chk("R1", "A dir read", rd_a, 8'h00);
    chk("R1", "B dir read", rd_b, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: directed set then clear on B
    bus_write(4'h8, 8'hFF);
    bus_write(4'h4, 8'h0F);
    bus_write(4'h8, 8'h03);
    addr = 4'h4;
    #1 chk("R3", "B latch after set/clear", out_b, 8'h0C);
    chk("R4", "B set read", rd_b, 8'h0C);
    addr = 4'h8;
    #1 chk("R4", "B clear read", rd_b, 8'h0C);

    // R9: input change seen after two edges, not one
    pin = 8'h00;
    repeat (3) @(negedge clk);
    addr = 4'h0;
    pin = 8'hA5;
    @(negedge clk);
    chk("R9", "C data one edge later", rd_c, 8'h00);
    @(negedge clk);
    chk("R9", "C data two edges later", rd_c, 8'hA5);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check_all();
      case ($urandom % 6)
        0: addr = 4'h0;
        1: addr = 4'h4;
        2: addr = 4'h8;
        3: addr = 4'hC;
        default: addr = 4'($urandom);
      endcase
      we  = ($urandom % 3) != 0;
      wd  = 8'($urandom);
      if (($urandom % 4) == 0) pin = 8'($urandom);
      // R12: read data follows the new address before any edge
      #1 chk("R12", "C rdata same cycle", rd_c, exp_rd_c(addr));
    end
    @(negedge clk);
    check_all();
    finish_run();
  end

endmodule